// File: doc/BRIEF.md
# Peripheral Interrupt Vector Arbiter

The block gathers eleven peripheral interrupt requests into one interrupt line toward a processor core. Each request pulse sets a pending bit. When no vector is waiting, the arbiter picks the pending source with the highest priority. It loads that source's service address into a vector register and raises the interrupt output.

The vector register stays frozen until the processor reads it. This holds even if other sources, including higher-priority ones, become pending in the meantime. The read does three things: it lowers the interrupt, it clears the pending bit of the source that was reported, and it lets the next pending source be chosen one cycle later. The core-side interrupt latch and the service routines lie outside this block.

Top module: `pirq_vector_arb`

## Requirements
- R1: After reset, `irq_o` is low and `vec_o` is 0x0000.
- R2: A one-cycle pulse on `req_i[i]`, sampled at clock edge k with nothing else pending, gives `irq_o` high and `vec_o` = 0x0030 + 4*i after edge k+1.
- R3: When several sources are pending while no vector waits, the lowest source index wins. Index 0 has the highest priority and index 10 the lowest.
- R4: While `irq_o` is high, `vec_o` does not change until a read, even if new requests arrive, including higher-priority ones.
- R5: A read (`rd_i` high at an edge while `irq_o` is high) drops `irq_o` after that edge and clears the pending bit of the reported source.
- R6: If sources are still pending after a read, `irq_o` rises again one edge after the read edge, with the vector of the next-highest-priority pending source.
- R7: A read while `irq_o` is low has no effect: `irq_o` stays low and `vec_o` keeps its value.
- R8: A request that arrives while a vector waits stays pending and is served later. This includes a request from the reported source in the same cycle as its read, which re-arms that source.
- R9: With all eleven sources pending, repeated reads report vectors 0x0030 through 0x0058 in ascending order, each exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 11 | Peripheral request pulses, one bit per source |
| rd_i | input | 1 | Vector register read strobe |
| vec_o | output | 16 | Vector register contents |
| irq_o | output | 1 | Interrupt request toward the core |

## Verification
Lost or stuck pending state shows at the ports during the drain that follows a read. A lost bit shows up as a missing vector. A stuck bit shows up as a repeated vector or an interrupt that never drops, and either one appears within one cycle of the read. A broken priority order or a vector register that is not frozen changes `vec_o` on the very next sample. The bench therefore checks `irq_o` and `vec_o` on every cycle of every drain sequence, not only at the end.

// File: rtl/pva_pkg.sv
package pva_pkg;
  localparam int unsigned VEC_W = 16;
  typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/pva_pending.sv
module pva_pending #(
  parameter int unsigned NUM_SRC = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] pend_q;

  // set wins over clear: a fresh request re-arms its source
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

  // R5
  clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));

  // R8
  set_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/pva_prio.sv
module pva_prio #(
  parameter int unsigned NUM_SRC = 11,
  parameter int unsigned IDX_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |pend_i;
endmodule

// File: rtl/pva_vec_reg.sv
module pva_vec_reg
  import pva_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 11,
  parameter int unsigned IDX_W    = $clog2(NUM_SRC),
  parameter int unsigned VEC_BASE = 'h30,
  parameter int unsigned VEC_STEP = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hit_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               rd_i,
  output vec_t               vec_o,
  output logic               irq_o,
  output logic [NUM_SRC-1:0] clr_o
);
  localparam int unsigned VEC_LAST = VEC_BASE + VEC_STEP * (NUM_SRC - 1);

  logic             valid_q;
  logic [IDX_W-1:0] src_q;
  vec_t             vec_q;
  logic             take;

  assign take = valid_q && rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      src_q   <= '0;
      vec_q   <= '0;
    end else if (take) begin
      valid_q <= 1'b0;
    end else if (!valid_q && hit_i) begin
      valid_q <= 1'b1;
      src_q   <= idx_i;
      vec_q   <= vec_t'(VEC_BASE + VEC_STEP * int'(idx_i));
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_clr
    assign clr_o[g] = take && (src_q == IDX_W'(g));
  end

  assign vec_o = vec_q;
  assign irq_o = valid_q;

  // R4
  vec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !rd_i) |=> (irq_o && $stable(vec_o)));

  // R5
  rd_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && rd_i) |=> !irq_o);

  // R7
  idle_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !hit_i) |=> (!irq_o && $stable(vec_o)));

  // R2
  vec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vec_o >= vec_t'(VEC_BASE) && vec_o <= vec_t'(VEC_LAST)));

  // R5
  clr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_o));
endmodule

// File: rtl/pirq_vector_arb.sv
module pirq_vector_arb
  import pva_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 11,
  parameter int unsigned VEC_BASE = 'h30,
  parameter int unsigned VEC_STEP = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               rd_i,
  output logic [VEC_W-1:0]   vec_o,
  output logic               irq_o
);
  localparam int unsigned IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] clr;
  logic               hit;
  logic [IDX_W-1:0]   idx;

  pva_pending #(.NUM_SRC(NUM_SRC)) u_pending (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (req_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  pva_prio #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .pend_i (pend),
    .hit_o  (hit),
    .idx_o  (idx)
  );

  pva_vec_reg #(
    .NUM_SRC  (NUM_SRC),
    .IDX_W    (IDX_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
  ) u_vec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .idx_i  (idx),
    .rd_i   (rd_i),
    .vec_o  (vec_o),
    .irq_o  (irq_o),
    .clr_o  (clr)
  );

  // R6
  rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|pend));
endmodule

// File: tb/pirq_vector_arb_bench.sv
module pirq_vector_arb_bench;
  localparam int NSRC = 11;
  localparam int NTAB = 6;
  localparam logic [NSRC-1:0] REQ_TAB [NTAB] = '{
    11'b000_0000_0001, 11'b100_0000_0000, 11'b000_0010_0100,
    11'b101_0101_0101, 11'b011_0000_1000, 11'b111_1111_1111
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NSRC-1:0]  req = '0;
  logic             rd = 1'b0;
  logic [15:0]      vec;
  logic             irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pirq_vector_arb u_pirq_vector_arb (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .rd_i(rd), .vec_o(vec), .irq_o(irq)
  );

  task automatic chk(string rq, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] vec_of(int i);
    return 16'(16'h30 + 4 * i);
  endfunction

  function automatic int lowest(logic [NSRC-1:0] m);
    for (int i = NSRC - 1; i >= 0; i--) if (m[i]) lowest = i;
  endfunction

  // returns at the negedge after the sampling edge
  task automatic pulse(logic [NSRC-1:0] m);
    req = m;
    @(negedge clk);
    req = '0;
  endtask

  task automatic do_read(string rq);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk(rq, 16'(irq), 16'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1
    chk("R1 irq", 16'(irq), 16'd0);
    chk("R1 vec", vec, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // table: R2 R3 R6 R9
    for (int t = 0; t < NTAB; t++) begin
      logic [NSRC-1:0] rem;
      rem = REQ_TAB[t];
      pulse(rem);
      while (rem != '0) begin
        int s;
        @(negedge clk);
        s = lowest(rem);
        chk("R2/R3/R6/R9 irq", 16'(irq), 16'd1);
        chk("R2/R3/R6/R9 vec", vec, vec_of(s));
        do_read("R5 drop");
        rem[s] = 1'b0;
      end
      @(negedge clk);
      chk("R5 idle after drain", 16'(irq), 16'd0);
    end

    // R4: frozen while a higher-priority request arrives
    pulse(11'b000_0010_0000);
    @(negedge clk);
    chk("R4 vec", vec, 16'h0044);
    pulse(11'b000_0000_0001);
    @(negedge clk);
    chk("R4 held irq", 16'(irq), 16'd1);
    chk("R4 held vec", vec, 16'h0044);
    do_read("R5 drop");
    @(negedge clk);
    chk("R8 late request vec", vec, 16'h0030);
    do_read("R5 drop");

    // R7: read while idle has no effect
    @(negedge clk);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk("R7 irq", 16'(irq), 16'd0);
    chk("R7 vec", vec, 16'h0030);
    pulse(11'b000_0000_1000);
    @(negedge clk);
    chk("R7 later vec", vec, 16'h003C);
    do_read("R5 drop");

    // R8: same source re-requested in its read cycle
    pulse(11'b000_0000_0100);
    @(negedge clk);
    chk("R8 first vec", vec, 16'h0038);
    rd = 1'b1;
    req = 11'b000_0000_0100;
    @(negedge clk);
    rd = 1'b0;
    req = '0;
    chk("R8 drop", 16'(irq), 16'd0);
    @(negedge clk);
    chk("R8 rearm irq", 16'(irq), 16'd1);
    chk("R8 rearm vec", vec, 16'h0038);
    do_read("R5 drop");
    @(negedge clk);
    chk("R5 cleared", 16'(irq), 16'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule